// File: doc/BRIEF.md
# Programmable SCL Clock Generator

This block produces the serial clock of a two-wire bus master from a 4 MHz system clock. A control word holds a 5-bit divisor code, a speed-mode bit and a bit that selects eight or nine clocks per byte. Writing that word also restarts the generator. While idle the clock line is released high. A byte request then yields a burst of clock periods. Each period has a low phase followed by a high phase. A stop request ends the burst once the current period has finished.

Two single-cycle strobes mark the clock edges for the data path around the block. One fires in the first cycle that SCL is low, which is when a new data bit may be driven. The other fires in the first cycle that SCL is high, which is when the bus is sampled. Shifting data, framing on the data line and arbitration all belong to other blocks.

Top module: `scl_clkgen`

## Requirements
- R1: After reset the stored control word is all zeros (code 0, standard mode, eight clocks). SCL is high, both strobes are low, and a byte request does nothing.
- R2: Codes 0, 1 and 2 are illegal in both modes. Codes 3 and 4 are illegal in standard mode (mode bit 0). With an illegal code, a byte request is ignored, SCL stays high and no strobe fires.
- R3: In standard mode with a legal code N (5 to 31), each SCL period is 4*N cycles low followed by 4*N cycles high.
- R4: In high-speed mode (mode bit 1) with a legal code N other than 5, each period is 2*N cycles low followed by 2*N cycles high.
- R5: In high-speed mode with code 5, each period is 6 cycles low followed by 4 cycles high.
- R6: `tick_fall` is high for exactly one cycle, the first cycle of each low phase. `tick_rise` is high for exactly one cycle, the first cycle of each high phase. The two never fire together.
- R7: A byte request gives 8 clock periods when the nine-clock bit is 0 and 9 when it is 1. After the last high phase SCL stays high. The first low phase starts in the cycle after the request is sampled.
- R8: A stop request sampled during a period lets that period finish its high phase, and no further low phase follows.
- R9: A control write puts SCL high and the generator idle in the next cycle, even in mid-byte. A byte request in the same cycle as the write is ignored. Later bytes use the newly written settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Control word write strobe |
| cfg_div | input | 5 | Divisor code |
| cfg_fast | input | 1 | Speed mode: 0 standard, 1 high-speed |
| cfg_nine | input | 1 | 1 selects nine clocks per byte, 0 selects eight |
| byte_start | input | 1 | Request for one byte of clocks |
| byte_stop | input | 1 | Request to end the burst after the current period |
| scl | output | 1 | Serial clock, high when released |
| tick_rise | output | 1 | One-cycle strobe in the first high cycle |
| tick_fall | output | 1 | One-cycle strobe in the first low cycle |

## Verification
The assertions take for granted that a byte request is raised only while the generator is idle or right after a control write. They also assume that a stop request is raised only during a burst. The counter checks further rely on the phase lengths being at least one cycle, which every legal code gives. The directed tasks keep within these limits: they space byte requests past the end of the previous burst, and they raise a stop request only inside a low phase that is under way.

// File: rtl/scl_pkg.sv
package scl_pkg;

  localparam int unsigned DIV_W = 5;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  typedef struct packed {
    logic             nine;
    logic             fast;
    logic [DIV_W-1:0] div;
  } scl_cfg_t;

endpackage

// File: rtl/scl_timing.sv
module scl_timing
  import scl_pkg::*;
#(
  parameter int unsigned STD_MUL      = 8,
  parameter int unsigned FAST_MUL     = 4,
  parameter int unsigned STD_MIN      = 5,
  parameter int unsigned FAST_MIN     = 3,
  parameter int unsigned SPECIAL_CODE = 5,
  parameter int unsigned SPECIAL_LOW  = 6,
  parameter int unsigned SPECIAL_HIGH = 4,
  parameter int unsigned CNT_W        = 7
) (
  input  logic [DIV_W-1:0] div,
  input  logic             fast,
  output logic             legal,
  output logic [CNT_W-1:0] low_len,
  output logic [CNT_W-1:0] high_len
);

  localparam int unsigned STD_HALF  = STD_MUL / 2;
  localparam int unsigned FAST_HALF = FAST_MUL / 2;

  logic [CNT_W-1:0] std_half_len;
  logic [CNT_W-1:0] fast_half_len;
  logic             special_sel;

  always_comb begin
    std_half_len  = CNT_W'(div) * CNT_W'(STD_HALF);
    fast_half_len = CNT_W'(div) * CNT_W'(FAST_HALF);
    special_sel   = fast && (div == DIV_W'(SPECIAL_CODE));
    if (fast) begin
      legal = (div >= DIV_W'(FAST_MIN));
    end else begin
      legal = (div >= DIV_W'(STD_MIN));
    end
    if (special_sel) begin
      low_len  = CNT_W'(SPECIAL_LOW);
      high_len = CNT_W'(SPECIAL_HIGH);
    end else if (fast) begin
      low_len  = fast_half_len;
      high_len = fast_half_len;
    end else begin
      low_len  = std_half_len;
      high_len = std_half_len;
    end
  end

endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load || dec) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

  // R3: a phase never counts past its end
  assert_ctr_no_underflow_R3: assert property (
    @(posedge clk) disable iff (!rst_n) dec |-> !zero);

  // R6: loading a new phase and counting one down are exclusive
  assert_ctr_load_excl_R6: assert property (
    @(posedge clk) disable iff (!rst_n) !(load && dec));

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_pkg::*;
#(
  parameter int unsigned STD_MUL      = 8,
  parameter int unsigned FAST_MUL     = 4,
  parameter int unsigned STD_MIN      = 5,
  parameter int unsigned FAST_MIN     = 3,
  parameter int unsigned SPECIAL_CODE = 5,
  parameter int unsigned SPECIAL_LOW  = 6,
  parameter int unsigned SPECIAL_HIGH = 4,
  parameter int unsigned BYTE_BITS    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_fast,
  input  logic             cfg_nine,
  input  logic             byte_start,
  input  logic             byte_stop,
  output logic             scl,
  output logic             tick_rise,
  output logic             tick_fall
);

  localparam int unsigned MAX_PHASE = ((1 << DIV_W) - 1) * (STD_MUL / 2);
  localparam int unsigned CNT_W     = $clog2(MAX_PHASE + 1);
  localparam int unsigned BIT_W     = $clog2(BYTE_BITS + 2);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  scl_cfg_t         cfg_q, cfg_d;
  scl_phase_e       st_q, st_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             stop_q, stop_d;
  logic             scl_q, scl_d;
  logic             trise_q, trise_d;
  logic             tfall_q, tfall_d;

  logic             legal;
  logic [CNT_W-1:0] low_len;
  logic [CNT_W-1:0] high_len;
  logic             ctr_load;
  logic [CNT_W-1:0] ctr_val;
  logic             ctr_dec;
  logic             ctr_zero;
  logic [BIT_W-1:0] nbits;
  logic             last_bit;

  scl_timing #(
    .STD_MUL      (STD_MUL),
    .FAST_MUL     (FAST_MUL),
    .STD_MIN      (STD_MIN),
    .FAST_MIN     (FAST_MIN),
    .SPECIAL_CODE (SPECIAL_CODE),
    .SPECIAL_LOW  (SPECIAL_LOW),
    .SPECIAL_HIGH (SPECIAL_HIGH),
    .CNT_W        (CNT_W)
  ) u_timing (
    .div      (cfg_q.div),
    .fast     (cfg_q.fast),
    .legal    (legal),
    .low_len  (low_len),
    .high_len (high_len)
  );

  scl_phase_ctr #(
    .CNT_W (CNT_W)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (ctr_load),
    .load_val (ctr_val),
    .dec      (ctr_dec),
    .zero     (ctr_zero)
  );

  assign nbits    = BIT_W'(BYTE_BITS) + BIT_W'(cfg_q.nine);
  assign last_bit = ((bit_q + BIT_W'(1)) == nbits);

  always_comb begin
    cfg_d    = cfg_q;
    st_d     = st_q;
    bit_d    = bit_q;
    stop_d   = stop_q;
    scl_d    = scl_q;
    trise_d  = 1'b0;
    tfall_d  = 1'b0;
    ctr_load = 1'b0;
    ctr_val  = low_len - CNT_W'(1);
    ctr_dec  = 1'b0;
    if (cfg_we) begin
      cfg_d.div  = cfg_div;
      cfg_d.fast = cfg_fast;
      cfg_d.nine = cfg_nine;
      st_d       = PH_IDLE;
      bit_d      = '0;
      stop_d     = 1'b0;
      scl_d      = 1'b1;
      ctr_load   = 1'b1;
      ctr_val    = '0;
    end else begin
      unique case (st_q)
        PH_IDLE: begin
          if (byte_start && legal) begin
            st_d     = PH_LOW;
            scl_d    = 1'b0;
            tfall_d  = 1'b1;
            bit_d    = '0;
            stop_d   = 1'b0;
            ctr_load = 1'b1;
          end
        end
        PH_LOW: begin
          if (byte_stop) begin
            stop_d = 1'b1;
          end
          if (ctr_zero) begin
            st_d     = PH_HIGH;
            scl_d    = 1'b1;
            trise_d  = 1'b1;
            ctr_load = 1'b1;
            ctr_val  = high_len - CNT_W'(1);
          end else begin
            ctr_dec = 1'b1;
          end
        end
        PH_HIGH: begin
          if (ctr_zero) begin
            bit_d = bit_q + BIT_W'(1);
            if (last_bit || stop_q || byte_stop) begin
              st_d   = PH_IDLE;
              stop_d = 1'b0;
            end else begin
              st_d     = PH_LOW;
              scl_d    = 1'b0;
              tfall_d  = 1'b1;
              ctr_load = 1'b1;
            end
          end else begin
            ctr_dec = 1'b1;
            if (byte_stop) begin
              stop_d = 1'b1;
            end
          end
        end
        default: begin
          st_d  = PH_IDLE;
          scl_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q   <= '0;
      st_q    <= PH_IDLE;
      bit_q   <= '0;
      stop_q  <= 1'b0;
      scl_q   <= 1'b1;
      trise_q <= 1'b0;
      tfall_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        cfg_q <= cfg_d;
      end
      st_q    <= st_d;
      bit_q   <= bit_d;
      stop_q  <= stop_d;
      scl_q   <= scl_d;
      trise_q <= trise_d;
      tfall_q <= tfall_d;
    end
  end

  assign scl       = scl_q;
  assign tick_rise = trise_q;
  assign tick_fall = tfall_q;

  // R2: an illegal code keeps the line released and quiet
  assert_illegal_quiet_R2: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    !legal |-> (scl_q && !trise_q && !tfall_q));

  // R6: strobes never coincide
  assert_tick_excl_R6: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    $onehot0({trise_q, tfall_q}));

  // R6: the fall strobe sits on a real high-to-low change
  assert_fall_edge_R6: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    tfall_q |-> (!scl_q && $past(scl_q)));

  // R6: the rise strobe sits on a real low-to-high change
  assert_rise_edge_R6: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    trise_q |-> (scl_q && !$past(scl_q)));

  // R7: the period count never passes the byte length
  assert_bits_bound_R7: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    bit_q <= nbits);

  // R9: a control write parks the generator on the next edge
  assert_cfg_parks_R9: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    cfg_we |=> (scl_q && (st_q == PH_IDLE) && !tfall_q && !trise_q));

endmodule

// File: tb/scl_clkgen_bench.sv
module scl_clkgen_bench;

  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [4:0] cfg_div;
  logic       cfg_fast;
  logic       cfg_nine;
  logic       byte_start;
  logic       byte_stop;
  logic       scl;
  logic       tick_rise;
  logic       tick_fall;

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 0;

  scl_clkgen u_scl_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_div    (cfg_div),
    .cfg_fast   (cfg_fast),
    .cfg_nine   (cfg_nine),
    .byte_start (byte_start),
    .byte_stop  (byte_stop),
    .scl        (scl),
    .tick_rise  (tick_rise),
    .tick_fall  (tick_fall)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int div, input bit fast, input bit nine);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_div  = 5'(div);
    cfg_fast = fast;
    cfg_nine = nine;
    @(negedge clk);
    cfg_we   = 1'b0;
  endtask

  // watch for n cycles: line must stay high with no strobes
  task automatic watch_quiet(input string req, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (!scl || tick_rise || tick_fall) bad++;
      @(negedge clk);
    end
    check(bad == 0, req, "cycles with activity", bad, 0);
  endtask

  task automatic run_byte(input string req, input int exp_low, input int exp_high,
                          input int exp_n, input int stop_after);
    int  n_fall = 0;
    int  n_rise = 0;
    int  bad_low = 0;
    int  bad_high = 0;
    int  bad_tick = 0;
    int  run = 0;
    int  guard = 0;
    int  seen_low = -1;
    int  seen_high = -1;
    bit  prev = 1'b1;
    bit  started = 1'b0;
    bit  stop_sent = 1'b0;
    bit  done = 1'b0;
    logic s;
    @(negedge clk);
    byte_start = 1'b1;
    @(negedge clk);
    byte_start = 1'b0;
    while (!done && guard < 20000) begin
      s = scl;
      if ((tick_fall != (prev && !s)) || (tick_rise != (!prev && s))) bad_tick++;
      if (s != prev) begin
        if (started) begin
          if (!prev) begin
            seen_low = run;
            if (run != exp_low) bad_low++;
          end else begin
            seen_high = run;
            if (run != exp_high) bad_high++;
          end
        end
        started = 1'b1;
        run = 1;
        if (!s) n_fall++; else n_rise++;
      end else begin
        run++;
      end
      if (byte_stop) begin
        byte_stop = 1'b0;
      end else if (stop_after > 0 && !stop_sent && n_fall == stop_after && !s) begin
        byte_stop = 1'b1;
        stop_sent = 1'b1;
      end
      if (started && s && run > exp_high + 4) begin
        done = 1'b1;
        if (seen_high < 0) seen_high = exp_high;
      end
      prev = s;
      guard++;
      @(negedge clk);
    end
    check(done, req, "burst ended with line high", int'(done), 1);
    check(bad_low == 0, req, "low phase length", seen_low, exp_low);
    check(bad_high == 0, req, "high phase length", seen_high, exp_high);
    check(n_fall == exp_n, req, "falling edges", n_fall, exp_n);
    check(n_rise == exp_n, req, "rising edges", n_rise, exp_n);
    check(bad_tick == 0, "R6", "misplaced strobes", bad_tick, 0);
  endtask

  task automatic test_reset();
    check(scl === 1'b1, "R1", "scl after reset", int'(scl), 1);
    check(tick_rise === 1'b0 && tick_fall === 1'b0, "R1", "strobes after reset",
          int'({tick_rise, tick_fall}), 0);
    @(negedge clk);
    byte_start = 1'b1;
    @(negedge clk);
    byte_start = 1'b0;
    watch_quiet("R1", 60);
  endtask

  task automatic test_illegal();
    for (int c = 0; c < 5; c++) begin
      cfg_write(c, 1'b0, 1'b0);
      @(negedge clk);
      byte_start = 1'b1;
      @(negedge clk);
      byte_start = 1'b0;
      watch_quiet("R2", 60);
    end
    for (int c = 0; c < 3; c++) begin
      cfg_write(c, 1'b1, 1'b1);
      @(negedge clk);
      byte_start = 1'b1;
      @(negedge clk);
      byte_start = 1'b0;
      watch_quiet("R2", 60);
    end
  endtask

  task automatic test_standard();
    cfg_write(5, 1'b0, 1'b0);
    run_byte("R3", 20, 20, 8, 0);
    cfg_write(31, 1'b0, 1'b1);
    run_byte("R7", 124, 124, 9, 0);
    cfg_write(6, 1'b0, 1'b0);
    run_byte("R7", 24, 24, 8, 0);
  endtask

  task automatic test_fast();
    cfg_write(3, 1'b1, 1'b0);
    run_byte("R4", 6, 6, 8, 0);
    cfg_write(8, 1'b1, 1'b1);
    run_byte("R4", 16, 16, 9, 0);
  endtask

  task automatic test_special();
    cfg_write(5, 1'b1, 1'b0);
    run_byte("R5", 6, 4, 8, 0);
  endtask

  task automatic test_stop();
    cfg_write(4, 1'b1, 1'b0);
    run_byte("R8", 8, 8, 3, 3);
  endtask

  task automatic test_cfg_write();
    cfg_write(3, 1'b1, 1'b0);
    @(negedge clk);
    byte_start = 1'b1;
    @(negedge clk);
    byte_start = 1'b0;
    repeat (15) @(negedge clk);
    cfg_write(7, 1'b0, 1'b0);
    check(scl === 1'b1, "R9", "scl after mid-byte write", int'(scl), 1);
    watch_quiet("R9", 40);
    run_byte("R9", 28, 28, 8, 0);
    @(negedge clk);
    cfg_we     = 1'b1;
    cfg_div    = 5'd3;
    cfg_fast   = 1'b1;
    cfg_nine   = 1'b0;
    byte_start = 1'b1;
    @(negedge clk);
    cfg_we     = 1'b0;
    byte_start = 1'b0;
    watch_quiet("R9", 40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_checks++;
      $display("FAIL all: watchdog, actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    cfg_we     = 1'b0;
    cfg_div    = '0;
    cfg_fast   = 1'b0;
    cfg_nine   = 1'b0;
    byte_start = 1'b0;
    byte_stop  = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_illegal();
    test_standard();
    test_fast();
    test_special();
    test_stop();
    test_cfg_write();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule